// File: doc/BRIEF.md
# Video Sync Word Clamp Detector

This stage sits on a 10-bit parallel video input and lets 8-bit and 10-bit sources drive the same downstream path. It looks only at the upper eight bits of each incoming word. When all eight of those bits are zero, or all eight are one, the word is taken to be a reserved timing value. The two low bits are then overwritten to match the upper bits, so the output always carries a clean reserved code: 0x000 for the low case and 0x3FF for the high case.

An 8-bit source connects to bits 9 to 2, and its unused bits 1 and 0 may hold any value. Its 0x00 and 0xFF timing bytes still produce valid 10-bit codes. A bypass control switches the recognition off, so payloads that are not video pass through unchanged. The output word and a detect flag are registered on the rising edge of the parallel clock. The result for an input word appears one cycle after that word is sampled.

Top module: `sync_clamp`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `dout` is 0x000 and `sync_hit` is 0.
- R2: With bypass low, an input whose bits 9..2 are all zero (0x000 to 0x003) yields `dout` = 0x000 one clock later.
- R3: With bypass low, an input whose bits 9..2 are all one (0x3FC to 0x3FF) yields `dout` = 0x3FF one clock later.
- R4: With bypass low, `sync_hit` goes to 1 one clock after any input from R2 or R3. It is 0 one clock after every other input.
- R5: With bypass low, an input whose bits 9..2 are neither all zero nor all one appears on `dout` bit-exact one clock later.
- R6: With bypass high, every input, including the reserved ranges, appears on `dout` bit-exact one clock later, and `sync_hit` is 0.
- R7: An 8-bit source on bits 9..2 with byte 0x00 or 0xFF produces 0x000 or 0x3FF, whatever its bits 1..0 hold.
- R8: The output follows the input with exactly one cycle of latency, so back-to-back words appear on consecutive cycles in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Parallel word clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | High disables reserved-word recognition |
| din | input | 10 | Parallel input word |
| dout | output | 10 | Registered, clamped output word |
| sync_hit | output | 1 | Registered flag: reserved word recognised |

## Verification
The block holds only one register stage, so any fault shows at the ports on the very next cycle. A wrong compare width, or a swapped low and high case, shows as a low-bit pair that does not match the upper bits on a reserved code. A flag that does not track the clamp shows as `sync_hit` disagreeing with the word beside it. A bypass that leaks shows as a rewritten 0x001 or 0x3FE while bypass is high. A stale register shows as the previous word appearing where the current one belongs.

// File: rtl/sync_clamp.sv
module sync_clamp #(
  parameter int W = 10,
  parameter int LOW = 2
) (
  input  logic         pclk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         sync_hit
);
  localparam int HW = W - LOW;

  logic [HW-1:0] hi;
  logic is_lo, is_hi, hit;
  logic [W-1:0] nxt;

  assign hi    = din[W-1:LOW];
  assign is_lo = (hi == '0);
  assign is_hi = (hi == '1);
  assign hit   = !bypass && (is_lo || is_hi);
  assign nxt   = hit ? {hi, {LOW{is_hi}}} : din;

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      dout     <= '0;
      sync_hit <= 1'b0;
    end else begin
      dout     <= nxt;
      sync_hit <= hit;
    end
  end
endmodule

// File: rtl/sync_clamp_chk.sv
module sync_clamp_chk #(
  parameter int W = 10,
  parameter int LOW = 2
) (
  input logic         pclk,
  input logic         rst_n,
  input logic         bypass,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         sync_hit
);
  // R1
  rst_clear_chk: assert property (@(posedge pclk) !rst_n |=> (dout == '0 && !sync_hit));
  // R2
  low_clamp_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!bypass && din[W-1:LOW] == '0) |=> (dout == '0));
  // R3
  high_clamp_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!bypass && din[W-1:LOW] == '1) |=> (dout == '1));
  // R6
  bypass_pass_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    bypass |=> (dout == $past(din) && !sync_hit));
  // R4
  flag_code_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    sync_hit |-> (dout == '0 || dout == '1));
  // R5
  pass_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!bypass && din[W-1:LOW] != '0 && din[W-1:LOW] != '1) |=> (dout == $past(din) && !sync_hit));
endmodule

bind sync_clamp sync_clamp_chk #(.W(W), .LOW(LOW)) u_chk (.*);

// File: tb/sim_sync_clamp.sv
module sim_sync_clamp;
  logic pclk = 0, rst_n = 0, bypass = 0;
  logic [9:0] din = '0;
  logic [9:0] dout;
  logic sync_hit;
  int n_chk = 0, n_bad = 0;

  always #4 pclk = ~pclk;

  sync_clamp u0 (.pclk, .rst_n, .bypass, .din, .dout, .sync_hit);

  // {bypass, din, expected dout, expected flag}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 10'h000, 10'h000, 1'b1},   // R2
    {1'b0, 10'h001, 10'h000, 1'b1},   // R2
    {1'b0, 10'h002, 10'h000, 1'b1},   // R2 R7
    {1'b0, 10'h003, 10'h000, 1'b1},   // R2 R7
    {1'b0, 10'h3FC, 10'h3FF, 1'b1},   // R3 R7
    {1'b0, 10'h3FD, 10'h3FF, 1'b1},   // R3
    {1'b0, 10'h3FE, 10'h3FF, 1'b1},   // R3
    {1'b0, 10'h3FF, 10'h3FF, 1'b1},   // R3 R4
    {1'b0, 10'h004, 10'h004, 1'b0},   // R5
    {1'b0, 10'h3FB, 10'h3FB, 1'b0},   // R5
    {1'b0, 10'h200, 10'h200, 1'b0},   // R5
    {1'b0, 10'h1FF, 10'h1FF, 1'b0},   // R5 R4
    {1'b1, 10'h001, 10'h001, 1'b0},   // R6
    {1'b1, 10'h3FE, 10'h3FE, 1'b0},   // R6
    {1'b1, 10'h2AA, 10'h2AA, 1'b0},   // R6
    {1'b1, 10'h000, 10'h000, 1'b0}    // R6
  };

  task automatic check(input string req, input logic [9:0] ed, input logic ef);
    n_chk++;
    if (dout !== ed || sync_hit !== ef) begin
      n_bad++;
      $display("FAIL %s: dout=%h flag=%b expected dout=%h flag=%b", req, dout, sync_hit, ed, ef);
    end
  endtask

  task automatic apply(input logic b, input logic [9:0] d);
    @(negedge pclk);
    bypass = b;
    din = d;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: expected finish, actual hang");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    din = 10'h155;
    repeat (3) @(posedge pclk);
    @(negedge pclk);
    check("R1", 10'h000, 1'b0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21], VEC[i][20:11]);
      @(negedge pclk);
      check("R2-R7 vec", VEC[i][10:1], VEC[i][0]);
    end
    // R8: back-to-back stream, one-cycle latency
    apply(1'b0, 10'h123);
    apply(1'b0, 10'h002);
    check("R8", 10'h123, 1'b0);
    apply(1'b0, 10'h3FD);
    check("R8", 10'h000, 1'b1);
    apply(1'b0, 10'h0F0);
    check("R8", 10'h3FF, 1'b1);
    @(negedge pclk);
    check("R8", 10'h0F0, 1'b0);
    // R7: 8-bit byte 0xFF with every low-bit pattern
    for (int k = 0; k < 4; k++) begin
      apply(1'b0, {8'hFF, 2'(k)});
      @(negedge pclk);
      check("R7", 10'h3FF, 1'b1);
    end
    // R1: mid-run reset clears state
    apply(1'b0, 10'h3FF);
    rst_n = 0;
    @(negedge pclk);
    check("R1", 10'h000, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule